// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a word-addressed data cache built from a direct-mapped line array and a small, fully associative victim buffer. Each address maps to exactly one line in the main array. A line pushed out of the main array is not thrown away. It is parked in the victim buffer, so a later conflict on the same index can be served without a trip to memory. The buffer is searched only after the main array misses, which leaves the normal hit path as it is.

The processor side takes one request at a time through a valid/ready pair and returns one response pulse per request. On a victim-buffer hit, the requested line and the line currently in the main array trade places. On a full miss, the whole line is fetched over a line-wide memory port. The outgoing main line then takes the victim slot that was filled longest ago. If that slot holds a dirty line, the line is first written back to memory. Three counters report how each lookup ended.

Top module: `victim_dm_cache`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o and mem_req_valid_o are 0, all three counters are 0, and every line is invalid, so the first access to any address is a miss.
- R2: A main-array hit raises rsp_valid_o in the first cycle after the acceptance edge, makes no memory request, and increments only hit_cnt_o.
- R3: The address is a word address split as {tag[13:10], index[9:2], word[1:0]}. Two addresses with the same index and different tags compete for one main line.
- R4: A line displaced from the main array enters the victim buffer. A later access to it is a victim hit: the response comes in the second cycle after acceptance, no memory read is made, and only vhit_cnt_o increments.
- R5: On a victim hit, the requested line moves to the main array, and the line it displaces takes the same victim slot. That displaced line is then itself a victim hit.
- R6: When both structures miss, exactly one line read is issued at line address {tag,index}. The returned line is installed, the requested word is returned, and miss_cnt_o increments.
- R7: The victim buffer has 4 entries, filled in first-in, first-out order. The fifth insertion overwrites the oldest entry, which then misses, while the other three still hit.
- R8: A dirty line whose victim slot is about to be reused is written to memory before the refill read. A clean line is dropped without a write.
- R9: req_ready_o is 1 only when the cache is idle. It falls after an accepted request and stays 0 while that request is in flight.
- R10: Writes allocate on a miss, update only the selected word, mark the line dirty, and return the written word as response data.
- R11: A memory request that is not yet accepted keeps its valid, write flag and line address unchanged until mem_req_ready_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request valid |
| req_ready_o | output | 1 | Cache idle and able to accept |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 14 | Word address |
| req_wdata_i | input | 32 | Write word |
| rsp_valid_o | output | 1 | Response pulse, one per request |
| rsp_rdata_o | output | 32 | Read word, or the written word for writes |
| mem_req_valid_o | output | 1 | Memory line request valid |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_we_o | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_laddr_o | output | 12 | Line address {tag,index} |
| mem_req_wline_o | output | 128 | Write-back line data |
| mem_rsp_valid_i | input | 1 | Refill line valid |
| mem_rsp_line_i | input | 128 | Refill line data |
| hit_cnt_o | output | 16 | Main-array hit count |
| vhit_cnt_o | output | 16 | Victim-buffer hit count |
| miss_cnt_o | output | 16 | Full miss count |

## Verification
Two things can happen on the same clock edge during a miss. The victim slot at the head of the FIFO is reused for the outgoing main line, while that slot's own dirty line has to leave for memory. A refill into a fully loaded buffer can also have to evict while a swap or write-back is still due. The bench provokes the first case by dirtying a line and then forcing four further conflicting misses on one index. The overwritten entry then arrives at the head exactly as a fifth eviction needs its slot. The bench judges the result in two ways. It counts memory writes and records the last written line address. It then misses on that line later and expects the word that was written earlier.

// File: rtl/vc_pkg.sv
package vc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOKUP,
    S_WB,
    S_FILL_REQ,
    S_FILL_WAIT,
    S_RESP
  } state_e;

  typedef enum logic [1:0] {
    OUT_NONE = 2'd0,
    OUT_HIT  = 2'd1,
    OUT_VHIT = 2'd2,
    OUT_MISS = 2'd3
  } outcome_e;

endpackage

// File: rtl/vc_dm_array.sv
module vc_dm_array #(
  parameter int NUM_LINES = 256,
  parameter int TAG_W     = 4,
  parameter int LINE_W    = 128,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic              rd_dirty_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [LINE_W-1:0] rd_line_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_valid_i,
  input  logic              wr_dirty_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [LINE_W-1:0] wr_line_i
);

  logic [NUM_LINES-1:0] vld_q, dty_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];
  logic [LINE_W-1:0]    line_q[NUM_LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      dty_q <= '0;
    end else if (wr_en_i) begin
      vld_q[wr_idx_i] <= wr_valid_i;
      dty_q[wr_idx_i] <= wr_dirty_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      line_q[wr_idx_i] <= wr_line_i;
    end
  end

  assign rd_valid_o = vld_q[rd_idx_i];
  assign rd_dirty_o = dty_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_line_o  = line_q[rd_idx_i];

endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int DEPTH   = 4,
  parameter int LADDR_W = 12,
  parameter int LINE_W  = 128,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LADDR_W-1:0] look_laddr_i,
  output logic               hit_o,
  output logic [DEPTH-1:0]   hit_vec_o,
  output logic [SLOT_W-1:0]  hit_slot_o,
  output logic               hit_dirty_o,
  output logic [LINE_W-1:0]  hit_line_o,
  output logic [SLOT_W-1:0]  head_o,
  output logic               head_valid_o,
  output logic               head_dirty_o,
  output logic [LADDR_W-1:0] head_laddr_o,
  output logic [LINE_W-1:0]  head_line_o,
  input  logic               wr_en_i,
  input  logic [SLOT_W-1:0]  wr_slot_i,
  input  logic               wr_valid_i,
  input  logic               wr_dirty_i,
  input  logic [LADDR_W-1:0] wr_laddr_i,
  input  logic [LINE_W-1:0]  wr_line_i,
  input  logic               push_i
);

  logic [DEPTH-1:0]   vld_q, dty_q;
  logic [LADDR_W-1:0] la_q[DEPTH];
  logic [LINE_W-1:0]  ln_q[DEPTH];
  logic [SLOT_W-1:0]  head_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign hit_vec_o[g] = vld_q[g] && (la_q[g] == look_laddr_i);
  end

  always_comb begin
    hit_slot_o  = '0;
    hit_line_o  = '0;
    hit_dirty_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec_o[i]) begin
        hit_slot_o  = hit_slot_o | SLOT_W'(i);
        hit_line_o  = hit_line_o | ln_q[i];
        hit_dirty_o = hit_dirty_o | dty_q[i];
      end
    end
  end
  assign hit_o = |hit_vec_o;

  assign head_o       = head_q;
  assign head_valid_o = vld_q[head_q];
  assign head_dirty_o = dty_q[head_q];
  assign head_laddr_o = la_q[head_q];
  assign head_line_o  = ln_q[head_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      dty_q  <= '0;
      head_q <= '0;
    end else begin
      if (wr_en_i) begin
        vld_q[wr_slot_i] <= wr_valid_i;
        dty_q[wr_slot_i] <= wr_dirty_i;
      end
      if (push_i) head_q <= (head_q == SLOT_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      la_q[wr_slot_i] <= wr_laddr_i;
      ln_q[wr_slot_i] <= wr_line_i;
    end
  end

endmodule

// File: rtl/vc_perf_cnt.sv
module vc_perf_cnt #(
  parameter int CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  vc_pkg::outcome_e   outcome_i,
  output logic [CNT_W-1:0]   hit_cnt_o,
  output logic [CNT_W-1:0]   vhit_cnt_o,
  output logic [CNT_W-1:0]   miss_cnt_o
);

  logic [CNT_W-1:0] cnt_q[3];

  for (genvar g = 0; g < 3; g++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q[g] <= '0;
      else if (outcome_i == vc_pkg::outcome_e'(g + 1)) cnt_q[g] <= cnt_q[g] + 1'b1;
    end
  end

  assign hit_cnt_o  = cnt_q[0];
  assign vhit_cnt_o = cnt_q[1];
  assign miss_cnt_o = cnt_q[2];

endmodule

// File: rtl/victim_dm_cache.sv
module victim_dm_cache #(
  parameter int ADDR_W     = 14,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 256,
  parameter int VB_DEPTH   = 4,
  parameter int CNT_W      = 16,
  localparam int WSEL_W    = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int TAG_W     = ADDR_W - IDX_W - WSEL_W,
  localparam int LADDR_W   = TAG_W + IDX_W,
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_we_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [WORD_W-1:0]  req_wdata_i,
  output logic               rsp_valid_o,
  output logic [WORD_W-1:0]  rsp_rdata_o,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic               mem_req_we_o,
  output logic [LADDR_W-1:0] mem_req_laddr_o,
  output logic [LINE_W-1:0]  mem_req_wline_o,
  input  logic               mem_rsp_valid_i,
  input  logic [LINE_W-1:0]  mem_rsp_line_i,
  output logic [CNT_W-1:0]   hit_cnt_o,
  output logic [CNT_W-1:0]   vhit_cnt_o,
  output logic [CNT_W-1:0]   miss_cnt_o
);
  import vc_pkg::*;

  localparam int SLOT_W = (VB_DEPTH > 1) ? $clog2(VB_DEPTH) : 1;

  function automatic logic [WORD_W-1:0] pick(input logic [LINE_W-1:0] ln,
                                             input logic [WSEL_W-1:0] ws);
    return ln[int'(ws)*WORD_W +: WORD_W];
  endfunction

  function automatic logic [LINE_W-1:0] merge(input logic [LINE_W-1:0] ln,
                                              input logic [WSEL_W-1:0] ws,
                                              input logic [WORD_W-1:0] wd);
    logic [LINE_W-1:0] r;
    r = ln;
    r[int'(ws)*WORD_W +: WORD_W] = wd;
    return r;
  endfunction

  state_e st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [WORD_W-1:0] wdata_q, rdata_q, rdata_d;
  logic              rdata_ld;

  logic [WSEL_W-1:0]  wsel;
  logic [IDX_W-1:0]   idx;
  logic [TAG_W-1:0]   tag;
  logic [LADDR_W-1:0] laddr;

  assign wsel  = addr_q[WSEL_W-1:0];
  assign idx   = addr_q[WSEL_W +: IDX_W];
  assign tag   = addr_q[ADDR_W-1 -: TAG_W];
  assign laddr = addr_q[ADDR_W-1:WSEL_W];

  // main array
  logic              m_valid, m_dirty;
  logic [TAG_W-1:0]  m_tag;
  logic [LINE_W-1:0] m_line;
  logic              m_wr, m_wr_dirty;
  logic [LINE_W-1:0] m_wr_line;

  vc_dm_array #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_array (
    .clk_i, .rst_ni,
    .rd_idx_i(idx), .rd_valid_o(m_valid), .rd_dirty_o(m_dirty),
    .rd_tag_o(m_tag), .rd_line_o(m_line),
    .wr_en_i(m_wr), .wr_idx_i(idx), .wr_valid_i(1'b1), .wr_dirty_i(m_wr_dirty),
    .wr_tag_i(tag), .wr_line_i(m_wr_line)
  );

  // victim buffer
  logic               v_hit, v_dirty, v_head_valid, v_head_dirty;
  logic [VB_DEPTH-1:0] v_hit_vec;
  logic [SLOT_W-1:0]  v_slot, v_head;
  logic [LINE_W-1:0]  v_line, v_head_line;
  logic [LADDR_W-1:0] v_head_laddr;
  logic               v_wr, v_push;
  logic [SLOT_W-1:0]  v_wr_slot;

  vc_victim_buf #(.DEPTH(VB_DEPTH), .LADDR_W(LADDR_W), .LINE_W(LINE_W)) u_victim (
    .clk_i, .rst_ni,
    .look_laddr_i(laddr),
    .hit_o(v_hit), .hit_vec_o(v_hit_vec), .hit_slot_o(v_slot),
    .hit_dirty_o(v_dirty), .hit_line_o(v_line),
    .head_o(v_head), .head_valid_o(v_head_valid), .head_dirty_o(v_head_dirty),
    .head_laddr_o(v_head_laddr), .head_line_o(v_head_line),
    .wr_en_i(v_wr), .wr_slot_i(v_wr_slot),
    .wr_valid_i(m_valid), .wr_dirty_i(m_dirty),
    .wr_laddr_i({m_tag, idx}), .wr_line_i(m_line),
    .push_i(v_push)
  );

  logic     lookup_st, m_hit, need_wb;
  outcome_e outcome;

  assign lookup_st = (st_q == S_LOOKUP);
  assign m_hit     = m_valid && (m_tag == tag);
  assign need_wb   = m_valid && v_head_valid && v_head_dirty;

  always_comb begin
    st_d            = st_q;
    m_wr            = 1'b0;
    m_wr_dirty      = 1'b0;
    m_wr_line       = m_line;
    v_wr            = 1'b0;
    v_wr_slot       = v_head;
    v_push          = 1'b0;
    rdata_ld        = 1'b0;
    rdata_d         = rdata_q;
    outcome         = OUT_NONE;
    mem_req_valid_o = 1'b0;
    mem_req_we_o    = 1'b0;
    mem_req_laddr_o = laddr;
    mem_req_wline_o = v_head_line;
    unique case (st_q)
      S_IDLE: if (req_valid_i) st_d = S_LOOKUP;
      S_LOOKUP: begin
        if (m_hit) begin
          outcome    = OUT_HIT;
          m_wr       = we_q;
          m_wr_dirty = 1'b1;
          m_wr_line  = merge(m_line, wsel, wdata_q);
          st_d       = S_IDLE;
        end else if (v_hit) begin
          // swap: victim line to main, displaced main line into the freed slot
          outcome    = OUT_VHIT;
          m_wr       = 1'b1;
          m_wr_dirty = v_dirty | we_q;
          m_wr_line  = we_q ? merge(v_line, wsel, wdata_q) : v_line;
          v_wr       = 1'b1;
          v_wr_slot  = v_slot;
          rdata_ld   = 1'b1;
          rdata_d    = we_q ? wdata_q : pick(v_line, wsel);
          st_d       = S_RESP;
        end else begin
          outcome = OUT_MISS;
          st_d    = need_wb ? S_WB : S_FILL_REQ;
        end
      end
      S_WB: begin
        mem_req_valid_o = 1'b1;
        mem_req_we_o    = 1'b1;
        mem_req_laddr_o = v_head_laddr;
        if (mem_req_ready_i) st_d = S_FILL_REQ;
      end
      S_FILL_REQ: begin
        mem_req_valid_o = 1'b1;
        if (mem_req_ready_i) st_d = S_FILL_WAIT;
      end
      S_FILL_WAIT: begin
        if (mem_rsp_valid_i) begin
          m_wr       = 1'b1;
          m_wr_dirty = we_q;
          m_wr_line  = we_q ? merge(mem_rsp_line_i, wsel, wdata_q) : mem_rsp_line_i;
          v_wr       = m_valid;
          v_push     = m_valid;
          rdata_ld   = 1'b1;
          rdata_d    = we_q ? wdata_q : pick(mem_rsp_line_i, wsel);
          st_d       = S_RESP;
        end
      end
      S_RESP:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (req_valid_i && req_ready_o) begin
        addr_q  <= req_addr_i;
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
      end
      if (rdata_ld) rdata_q <= rdata_d;
    end
  end

  assign req_ready_o = (st_q == S_IDLE);
  assign rsp_valid_o = (lookup_st && m_hit) || (st_q == S_RESP);
  assign rsp_rdata_o = lookup_st ? (we_q ? wdata_q : pick(m_line, wsel)) : rdata_q;

  vc_perf_cnt #(.CNT_W(CNT_W)) u_perf (
    .clk_i, .rst_ni, .outcome_i(outcome),
    .hit_cnt_o, .vhit_cnt_o, .miss_cnt_o
  );

endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
  parameter int VB_DEPTH = 4,
  parameter int LADDR_W  = 12,
  parameter int CNT_W    = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic               rsp_valid_o,
  input logic               mem_req_valid_o,
  input logic               mem_req_ready_i,
  input logic               mem_req_we_o,
  input logic [LADDR_W-1:0] mem_req_laddr_o,
  input logic               in_lookup,
  input logic               main_hit,
  input logic               vb_hit,
  input logic [VB_DEPTH-1:0] vb_hit_vec,
  input logic [CNT_W-1:0]   vhit_cnt_o,
  input logic [CNT_W-1:0]   miss_cnt_o
);

  p_accept_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  p_rsp_not_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  p_hit_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_lookup && main_hit |-> rsp_valid_o && !mem_req_valid_o);

  p_hit_no_side_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_lookup && main_hit |=> $stable(vhit_cnt_o) && $stable(miss_cnt_o));

  p_vhit_two_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_lookup && !main_hit && vb_hit |=> rsp_valid_o && !mem_req_valid_o);

  p_miss_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_lookup && !main_hit && !vb_hit |=> miss_cnt_o == CNT_W'($past(miss_cnt_o) + 1'b1));

  p_unique_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(vb_hit_vec));

  p_mem_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=>
      mem_req_valid_o && $stable(mem_req_laddr_o) && $stable(mem_req_we_o));

endmodule

bind victim_dm_cache vc_checker #(
  .VB_DEPTH(VB_DEPTH), .LADDR_W(LADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o),
  .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
  .mem_req_we_o(mem_req_we_o), .mem_req_laddr_o(mem_req_laddr_o),
  .in_lookup(lookup_st), .main_hit(m_hit), .vb_hit(v_hit), .vb_hit_vec(v_hit_vec),
  .vhit_cnt_o(vhit_cnt_o), .miss_cnt_o(miss_cnt_o)
);

// File: tb/victim_dm_cache_bench.sv
module victim_dm_cache_bench;

  localparam int K_HIT = 0, K_VHIT = 1, K_MISS = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic         req_valid = 1'b0, req_we = 1'b0;
  logic [13:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         req_ready_o, rsp_valid_o;
  logic [31:0]  rsp_rdata_o;
  logic         mem_req_valid_o, mem_req_we_o;
  logic [11:0]  mem_req_laddr_o;
  logic [127:0] mem_req_wline_o;
  logic         mem_rdy = 1'b0, mem_rsp_v = 1'b0;
  logic [127:0] mem_rsp_line = '0;
  logic [15:0]  hit_cnt_o, vhit_cnt_o, miss_cnt_o;

  victim_dm_cache u_victim_dm_cache (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_rdy),
    .mem_req_we_o(mem_req_we_o), .mem_req_laddr_o(mem_req_laddr_o),
    .mem_req_wline_o(mem_req_wline_o),
    .mem_rsp_valid_i(mem_rsp_v), .mem_rsp_line_i(mem_rsp_line),
    .hit_cnt_o(hit_cnt_o), .vhit_cnt_o(vhit_cnt_o), .miss_cnt_o(miss_cnt_o)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rd_cnt = 0, wr_cnt = 0, last_wr_la = -1;
  int tally[3] = '{0, 0, 0};
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // reference memory content
  logic [127:0] mem[int];
  logic [31:0]  shadow[int];

  function automatic logic [31:0] dflt_word(input int la, input int w);
    return 32'hD000_0000 + 32'(la * 16) + 32'(w);
  endfunction

  function automatic logic [127:0] line_of(input int la);
    logic [127:0] l;
    if (mem.exists(la)) return mem[la];
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = dflt_word(la, w);
    return l;
  endfunction

  // memory model: handshakes decided at the falling edge, seen at the next rising edge
  bit          pend = 1'b0, prev_stall = 1'b0, prev_we = 1'b0;
  int          dly = 0, pend_la = 0;
  logic [11:0] prev_la = '0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        if (prev_stall)
          chk(mem_req_valid_o && mem_req_laddr_o == prev_la && mem_req_we_o == prev_we,
              "R11", "stalled request changed", {20'd0, mem_req_laddr_o}, {20'd0, prev_la});
        mem_rsp_v = 1'b0;
        if (pend) begin
          if (dly == 0) begin
            mem_rsp_v = 1'b1;
            mem_rsp_line = line_of(pend_la);
            pend = 1'b0;
          end else dly--;
        end
        mem_rdy = (cyc % 3) != 1;
        prev_stall = mem_req_valid_o && !mem_rdy;
        prev_la = mem_req_laddr_o;
        prev_we = mem_req_we_o;
        if (mem_req_valid_o && mem_rdy) begin
          if (mem_req_we_o) begin
            mem[int'(mem_req_laddr_o)] = mem_req_wline_o;
            wr_cnt++;
            last_wr_la = int'(mem_req_laddr_o);
          end else begin
            pend = 1'b1;
            dly = 2;
            pend_la = int'(mem_req_laddr_o);
            rd_cnt++;
          end
        end
      end
    end
  end

  typedef struct {
    logic [31:0] data;
    int          kind;
    int          acc;
    int          rd_snap;
    string       rq;
  } exp_t;
  exp_t expq[$];

  // driver
  task automatic do_req(input int tg, input int ix, input int w, input bit we,
                        input logic [31:0] wd, input int kind, input string rq);
    exp_t e;
    int wa;
    wa = (tg << 10) | (ix << 2) | w;
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = 14'(wa);
    req_wdata = wd;
    if (we) shadow[wa] = wd;
    e.data    = shadow.exists(wa) ? shadow[wa] : dflt_word(wa >> 2, wa & 3);
    e.kind    = kind;
    e.acc     = cyc;
    e.rd_snap = rd_cnt;
    e.rq      = rq;
    expq.push_back(e);
    tally[kind]++;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready_o, "R9", "ready while busy", {31'd0, req_ready_o}, 32'd0);
  endtask

  task automatic drain();
    @(negedge clk);
    while (expq.size() != 0 || !req_ready_o) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && rsp_valid_o) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R9", "unexpected response", rsp_rdata_o, 32'd0);
      end else begin
        exp_t e;
        int lat;
        e = expq.pop_front();
        lat = cyc - e.acc;
        chk(rsp_rdata_o == e.data, e.rq, "data", rsp_rdata_o, e.data);
        chk(!req_ready_o, "R9", "ready during response", {31'd0, req_ready_o}, 32'd0);
        case (e.kind)
          K_HIT: begin
            chk(lat == 1, "R2", "hit latency", lat, 1);
            chk(rd_cnt == e.rd_snap, "R2", "hit made memory read", rd_cnt, e.rd_snap);
          end
          K_VHIT: begin
            chk(lat == 2, "R4", "victim hit latency", lat, 2);
            chk(rd_cnt == e.rd_snap, "R4", "victim hit made memory read", rd_cnt, e.rd_snap);
          end
          default: begin
            chk(lat >= 3, "R6", "miss latency", lat, 3);
            chk(rd_cnt == e.rd_snap + 1, "R6", "miss read count", rd_cnt, e.rd_snap + 1);
          end
        endcase
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 32'd0, 32'd1);
    report();
  end

  initial begin
    int wr0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready_o == 1'b1, "R1", "ready", {31'd0, req_ready_o}, 32'd1);
    chk(rsp_valid_o == 1'b0, "R1", "rsp_valid", {31'd0, rsp_valid_o}, 32'd0);
    chk(mem_req_valid_o == 1'b0, "R1", "mem valid", {31'd0, mem_req_valid_o}, 32'd0);
    chk(hit_cnt_o == 0 && vhit_cnt_o == 0 && miss_cnt_o == 0, "R1", "counters",
        {hit_cnt_o, vhit_cnt_o}, 32'd0);

    // cold miss, hits, write on hit
    do_req(0, 5, 0, 1'b0, '0, K_MISS, "R1");
    do_req(0, 5, 1, 1'b0, '0, K_HIT, "R2");
    do_req(0, 5, 2, 1'b1, 32'hCAFE_0001, K_HIT, "R10");
    do_req(0, 5, 2, 1'b0, '0, K_HIT, "R10");
    do_req(0, 5, 3, 1'b0, '0, K_HIT, "R10");
    // conflict on index 5 evicts dirty tag 0 into victim slot 0
    do_req(1, 5, 0, 1'b0, '0, K_MISS, "R3");
    do_req(0, 5, 2, 1'b0, '0, K_VHIT, "R4");
    do_req(1, 5, 3, 1'b0, '0, K_VHIT, "R5");
    // FIFO fill: tags 1,2,3 go into slots 1..3
    do_req(2, 5, 0, 1'b0, '0, K_MISS, "R7");
    do_req(3, 5, 0, 1'b0, '0, K_MISS, "R7");
    do_req(4, 5, 0, 1'b0, '0, K_MISS, "R7");
    drain();
    wr0 = wr_cnt;
    chk(wr_cnt == 0, "R8", "no write-back yet", wr_cnt, 0);
    // fifth insertion reuses slot 0 which holds dirty tag 0
    do_req(5, 5, 0, 1'b0, '0, K_MISS, "R8");
    drain();
    chk(wr_cnt == wr0 + 1, "R8", "write-back count", wr_cnt, wr0 + 1);
    chk(last_wr_la == 12'h005, "R8", "write-back line address", last_wr_la, 32'h005);
    // oldest entry is gone: miss, dirty word comes back from memory
    do_req(0, 5, 2, 1'b0, '0, K_MISS, "R7");
    do_req(2, 5, 1, 1'b0, '0, K_VHIT, "R7");
    do_req(1, 5, 0, 1'b0, '0, K_MISS, "R7");
    drain();
    chk(wr_cnt == wr0 + 1, "R8", "clean line dropped", wr_cnt, wr0 + 1);
    // write-allocate on another index
    do_req(3, 9, 1, 1'b1, 32'h1234_5678, K_MISS, "R10");
    do_req(3, 9, 1, 1'b0, '0, K_HIT, "R10");
    do_req(3, 9, 0, 1'b0, '0, K_HIT, "R10");
    drain();
    repeat (2) @(negedge clk);
    chk(hit_cnt_o == 16'(tally[K_HIT]), "R2", "hit counter", hit_cnt_o, tally[K_HIT]);
    chk(vhit_cnt_o == 16'(tally[K_VHIT]), "R4", "victim counter", vhit_cnt_o, tally[K_VHIT]);
    chk(miss_cnt_o == 16'(tally[K_MISS]), "R6", "miss counter", miss_cnt_o, tally[K_MISS]);
    chk(req_ready_o, "R9", "idle at end", {31'd0, req_ready_o}, 32'd1);
    report();
  end

endmodule